// File: doc/BRIEF.md
# Serial NOR Flash Device Front End

This block is the device side of a small serial NOR flash. A host drives a serial clock, a chip select and a data line into it. It returns data on an output line with a separate output enable. Inside, a shift engine samples the serial inputs using the system clock and finds the serial clock edges. A command decoder turns the first byte of each transaction into one operation. A status register holds a busy flag, a write-enable latch, three protection-level bits and a status-lock bit. A sequencer performs page program and erase on a scaled-down byte array.

The array keeps the usual granularity, scaled by parameters. With the defaults it has 16-byte pages, 64-byte sectors, 256-byte blocks and 4 blocks, which is 1024 bytes in total. The array starts out erased (0xFF). Program and erase take a fixed number of system clock cycles, set by parameters.

Serial inputs are sampled by `clk_i`. The serial clock must stay in each level for at least 3 system clock cycles.

Top module: `spi_nor_dev`

## Requirements
- R1: The serial interface works with the clock idling low or high. Data is sampled on the rising clock edge and output changes on the falling edge, MSB first. `so_oe_o` is 1 only while selected, not held, and in the output phase of a read-type command.
- R2: Read (0x03) takes a 3-byte address, of which the low 10 bits are used. It returns bytes from that address, incrementing the address after every byte and wrapping from 1023 to 0.
- R3: Status read (0x05) repeatedly returns the status byte. Bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protection level and bit 7 is the status lock. The other bits read 0, and the byte is 0x00 after reset.
- R4: ID read (0x9F) returns 0xA7, 0x3C, 0x14 and then repeats. Short ID (0xAB) followed by 3 dummy bytes returns 0x13.
- R5: 0x06 sets the write-enable latch and 0x04 clears it. Program, erase and status write run only when the latch is set. The latch clears when such an operation completes.
- R6: Page program (0x02, 3 address bytes, then data) ANDs the data into one page. The buffer starts at 0xFF, and the column starts at the low 4 address bits and wraps within the page.
- R7: Sector erase (0x20), block erase (0xD8) and chip erase (0xC7) set the addressed aligned region, or the whole array, to 0xFF.
- R8: Busy is set from the end of an accepted program or erase for span+OP_WAIT cycles, where span is the region size in bytes. While busy, every command except status read is ignored.
- R9: Protection level p protects the top min(4, 2^(p-1)) blocks; p=0 protects nothing. Program and erase into a protected block are ignored, and chip erase is ignored for any nonzero level.
- R10: Status write (0x01 plus one byte) loads the protection level from bits 4:2 and the lock from bit 7, then clears the latch. It is ignored when the lock is 1 and `wp_ni_i` is low.
- R11: A command runs only if select rises after exactly its length in bits. The lengths are 8 for 0x06, 0x04 and 0xC7, 16 for 0x01, and 32 for erase. Program needs a multiple of 8 bits, at least 40. Any other length is discarded.
- R12: While `hold_ni_i` is low, clock edges are ignored and `so_oe_o` is 0. A transfer resumes intact when it returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data in |
| hold_ni_i | input | 1 | Active-low pause |
| wp_ni_i | input | 1 | Active-low status write guard |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |

## Verification
A serial input is seen two system cycles after it changes. Output data therefore settles within three cycles of a falling serial clock edge. The bench holds each clock level for four cycles and samples `so_o` just before each rising edge, so every sample falls after the data has settled.

An accepted program or erase raises busy within three cycles of select rising. A status read started at once loads its status byte about 70 cycles later, well inside the shortest busy window of OP_WAIT plus 16 cycles. To check that the operation has finished, the bench waits at least span+OP_WAIT+20 cycles before polling again, and only then expects busy and the latch to be clear and the array to match its model.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_PROG = 8'h02;
  localparam logic [7:0] CMD_SEC  = 8'h20;
  localparam logic [7:0] CMD_BLK  = 8'hD8;
  localparam logic [7:0] CMD_CHIP = 8'hC7;
  localparam logic [7:0] CMD_WEN  = 8'h06;
  localparam logic [7:0] CMD_WDIS = 8'h04;
  localparam logic [7:0] CMD_STAT = 8'h05;
  localparam logic [7:0] CMD_WSTA = 8'h01;
  localparam logic [7:0] CMD_ID   = 8'h9F;
  localparam logic [7:0] CMD_SID  = 8'hAB;

  typedef enum logic [1:0] {K_PROG, K_SEC, K_BLK, K_CHIP} op_kind_e;
endpackage

// File: rtl/sfl_spi_if.sv
module sfl_spi_if #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cs_ni_i,
  input  logic             si_i,
  input  logic             hold_ni_i,
  input  logic             out_en_i,
  input  logic [7:0]       tx_byte_i,
  output logic             sel_o,
  output logic             cs_fall_o,
  output logic             cs_rise_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_byte_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             tx_req_o,
  output logic             so_o,
  output logic             so_oe_o
);
  logic sclk_q, sclk_d, cs_q, cs_d, si_q, hold_q;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic [2:0] tx_left;
  logic [CNT_W-1:0] cnt;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0; sclk_d <= 1'b0;
      cs_q <= 1'b1; cs_d <= 1'b1;
      si_q <= 1'b0; hold_q <= 1'b1;
    end else begin
      sclk_q <= sclk_i; sclk_d <= sclk_q;
      cs_q <= cs_ni_i; cs_d <= cs_q;
      si_q <= si_i; hold_q <= hold_ni_i;
    end
  end

  assign sel_o     = !cs_q;
  assign cs_fall_o = !cs_q && cs_d;
  assign cs_rise_o = cs_q && !cs_d;
  assign rise      = sel_o && hold_q && sclk_q && !sclk_d;
  assign fall      = sel_o && hold_q && !sclk_q && sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh <= '0; cnt <= '0; tx_sh <= '0; tx_left <= '0;
    end else if (cs_fall_o) begin
      rx_sh <= '0; cnt <= '0; tx_sh <= '0; tx_left <= '0;
    end else begin
      if (rise) begin
        rx_sh <= {rx_sh[5:0], si_q};
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
      if (fall && out_en_i) begin
        if (tx_left == 3'd0) begin
          tx_sh   <= tx_byte_i;
          tx_left <= 3'd7;
        end else begin
          tx_sh   <= {tx_sh[6:0], 1'b0};
          tx_left <= tx_left - 3'd1;
        end
      end
    end
  end

  assign rx_valid_o = rise && (cnt[2:0] == 3'd7);
  assign rx_byte_o  = {rx_sh, si_q};
  assign bit_cnt_o  = cnt;
  assign tx_req_o   = fall && out_en_i && (tx_left == 3'd0);
  assign so_o       = tx_sh[7];
  assign so_oe_o    = sel_o && hold_q && out_en_i;
endmodule

// File: rtl/sfl_array.sv
module sfl_array import sfl_pkg::*; #(
  parameter int PAGE_BYTES = 16,
  parameter int SEC_BYTES  = 64,
  parameter int BLK_BYTES  = 256,
  parameter int MEM_BYTES  = 1024,
  parameter int OP_WAIT    = 200,
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_kind_e          kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pb_clr_i,
  input  logic              pb_we_i,
  input  logic [PAGE_W-1:0] pb_idx_i,
  input  logic [7:0]        pb_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int WAIT_W = $clog2(OP_WAIT + 1);
  typedef enum logic [1:0] {S_IDLE, S_WORK, S_WAIT} st_e;

  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  st_e st;
  op_kind_e kind_q;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W:0] left, span;
  logic [WAIT_W-1:0] wcnt;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    case (kind_i)
      K_PROG:  span = (ADDR_W+1)'(PAGE_BYTES);
      K_SEC:   span = (ADDR_W+1)'(SEC_BYTES);
      K_BLK:   span = (ADDR_W+1)'(BLK_BYTES);
      default: span = (ADDR_W+1)'(MEM_BYTES);
    endcase
    mask = ~(span[ADDR_W-1:0] - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; kind_q <= K_PROG; cur <= '0; left <= '0; wcnt <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
    end else begin
      if (pb_clr_i) begin
        for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'hFF;
      end else if (pb_we_i) begin
        pbuf[pb_idx_i] <= pb_data_i;
      end
      case (st)
        S_IDLE: if (start_i) begin
          kind_q <= kind_i;
          cur    <= addr_i & mask;
          left   <= span;
          st     <= S_WORK;
        end
        S_WORK: begin
          // one byte per cycle; program can only clear bits
          mem[cur] <= (kind_q == K_PROG) ? (mem[cur] & pbuf[cur[PAGE_W-1:0]]) : 8'hFF;
          cur  <= cur + 1'b1;
          left <= left - 1'b1;
          if (left == (ADDR_W+1)'(1)) begin
            st   <= S_WAIT;
            wcnt <= WAIT_W'(OP_WAIT - 1);
          end
        end
        default: begin
          if (wcnt == '0) st <= S_IDLE;
          else wcnt <= wcnt - 1'b1;
        end
      endcase
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = (st != S_IDLE);
  assign done_o    = (st == S_WAIT) && (wcnt == '0);
endmodule

// File: rtl/sfl_ctrl.sv
module sfl_ctrl import sfl_pkg::*; #(
  parameter int         ADDR_W   = 10,
  parameter int         PAGE_W   = 4,
  parameter int         BLOCKS   = 4,
  parameter int         CNT_W    = 16,
  parameter logic [7:0] MFR_ID   = 8'hA7,
  parameter logic [7:0] DEV_HI   = 8'h3C,
  parameter logic [7:0] DEV_LO   = 8'h14,
  parameter logic [7:0] SHORT_ID = 8'h13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              tx_req_i,
  input  logic              wp_ni_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [7:0]        rd_data_i,
  output logic              out_en_o,
  output logic [7:0]        tx_byte_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              pb_clr_o,
  output logic              pb_we_o,
  output logic [PAGE_W-1:0] pb_idx_o,
  output logic [7:0]        pb_data_o,
  output logic              op_start_o,
  output op_kind_e          op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              wel_o,
  output logic [2:0]        bp_o
);
  localparam int BLK_W = $clog2(BLOCKS);

  logic [7:0] opc, sr_new;
  logic [23:0] addr_q, addr_nx;
  logic blocked, wel, lock;
  logic [2:0] bp;
  logic [PAGE_W-1:0] col;
  logic [ADDR_W-1:0] rd_ptr;
  logic [1:0] id_idx;
  logic [CNT_W-4:0] byte_idx;
  logic [7:0] status;

  function automatic logic is_prot(input logic [ADDR_W-1:0] a, input logic [2:0] lvl);
    int n;
    if (lvl == 3'd0) n = 0;
    else if (int'(lvl) - 1 >= BLK_W) n = BLOCKS;
    else n = 1 << (int'(lvl) - 1);
    return int'(a[ADDR_W-1 -: BLK_W]) >= BLOCKS - n;
  endfunction

  assign byte_idx = bit_cnt_i[CNT_W-1:3];
  assign addr_nx  = {addr_q[15:0], rx_byte_i};
  assign status   = {lock, 2'b00, bp, wel, busy_i};

  always_comb begin
    out_en_o = 1'b0;
    if (sel_i && !blocked) begin
      case (opc)
        CMD_READ, CMD_SID: out_en_o = bit_cnt_i >= CNT_W'(32);
        CMD_STAT, CMD_ID:  out_en_o = bit_cnt_i >= CNT_W'(8);
        default:           out_en_o = 1'b0;
      endcase
    end
    case (opc)
      CMD_READ: tx_byte_o = rd_data_i;
      CMD_STAT: tx_byte_o = status;
      CMD_ID:   tx_byte_o = (id_idx == 2'd0) ? MFR_ID : (id_idx == 2'd1) ? DEV_HI : DEV_LO;
      CMD_SID:  tx_byte_o = SHORT_ID;
      default:  tx_byte_o = 8'h00;
    endcase
  end

  assign pb_clr_o  = rx_valid_i && byte_idx == '0 && rx_byte_i == CMD_PROG && !busy_i;
  assign pb_we_o   = rx_valid_i && byte_idx >= (CNT_W-3)'(4) && opc == CMD_PROG && !blocked;
  assign pb_idx_o  = col;
  assign pb_data_o = rx_byte_i;
  assign rd_addr_o = rd_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc <= 8'h00; sr_new <= 8'h00; addr_q <= '0; blocked <= 1'b0;
      wel <= 1'b0; lock <= 1'b0; bp <= 3'd0; col <= '0; rd_ptr <= '0;
      id_idx <= 2'd0; op_start_o <= 1'b0; op_kind_o <= K_PROG; op_addr_o <= '0;
    end else begin
      op_start_o <= 1'b0;
      if (cs_fall_i) begin
        opc <= 8'h00; blocked <= 1'b0; id_idx <= 2'd0;
      end
      if (rx_valid_i) begin
        if (byte_idx == '0) begin
          opc     <= rx_byte_i;
          blocked <= busy_i && rx_byte_i != CMD_STAT;
        end else if (byte_idx <= (CNT_W-3)'(3)) begin
          addr_q <= addr_nx;
          if (byte_idx == (CNT_W-3)'(1)) sr_new <= rx_byte_i;
          if (byte_idx == (CNT_W-3)'(3)) begin
            col    <= rx_byte_i[PAGE_W-1:0];
            rd_ptr <= addr_nx[ADDR_W-1:0];
          end
        end else if (pb_we_o) begin
          col <= col + 1'b1;
        end
      end
      if (tx_req_i) begin
        rd_ptr <= rd_ptr + 1'b1;
        id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 2'd1;
      end
      if (done_i) wel <= 1'b0;
      if (cs_rise_i && !blocked) begin
        case (opc)
          CMD_WEN:  if (bit_cnt_i == CNT_W'(8)) wel <= 1'b1;
          CMD_WDIS: if (bit_cnt_i == CNT_W'(8)) wel <= 1'b0;
          CMD_WSTA: if (bit_cnt_i == CNT_W'(16) && wel && !(lock && !wp_ni_i)) begin
            bp   <= sr_new[4:2];
            lock <= sr_new[7];
            wel  <= 1'b0;
          end
          CMD_PROG: if (bit_cnt_i >= CNT_W'(40) && bit_cnt_i[2:0] == 3'd0 && wel &&
                        !is_prot(addr_q[ADDR_W-1:0], bp)) begin
            op_start_o <= 1'b1; op_kind_o <= K_PROG; op_addr_o <= addr_q[ADDR_W-1:0];
          end
          CMD_SEC, CMD_BLK: if (bit_cnt_i == CNT_W'(32) && wel &&
                                !is_prot(addr_q[ADDR_W-1:0], bp)) begin
            op_start_o <= 1'b1;
            op_kind_o  <= (opc == CMD_SEC) ? K_SEC : K_BLK;
            op_addr_o  <= addr_q[ADDR_W-1:0];
          end
          CMD_CHIP: if (bit_cnt_i == CNT_W'(8) && wel && bp == 3'd0) begin
            op_start_o <= 1'b1; op_kind_o <= K_CHIP; op_addr_o <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  assign wel_o = wel;
  assign bp_o  = bp;
endmodule

// File: rtl/spi_nor_dev.sv
module spi_nor_dev import sfl_pkg::*; #(
  parameter int         PAGE_BYTES    = 16,
  parameter int         PAGES_PER_SEC = 4,
  parameter int         SECS_PER_BLK  = 4,
  parameter int         BLOCKS        = 4,
  parameter int         OP_WAIT       = 200,
  parameter logic [7:0] MFR_ID        = 8'hA7,
  parameter logic [7:0] DEV_HI        = 8'h3C,
  parameter logic [7:0] DEV_LO        = 8'h14,
  parameter logic [7:0] SHORT_ID      = 8'h13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni_i,
  input  logic si_i,
  input  logic hold_ni_i,
  input  logic wp_ni_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int SEC_BYTES = PAGE_BYTES * PAGES_PER_SEC;
  localparam int BLK_BYTES = SEC_BYTES * SECS_PER_BLK;
  localparam int MEM_BYTES = BLK_BYTES * BLOCKS;
  localparam int ADDR_W    = $clog2(MEM_BYTES);
  localparam int PAGE_W    = $clog2(PAGE_BYTES);
  localparam int CNT_W     = 16;

  logic sel, cs_fall, cs_rise, rx_valid, tx_req, out_en;
  logic [7:0] rx_byte, tx_byte, rd_data, pb_data;
  logic [CNT_W-1:0] bit_cnt;
  logic [ADDR_W-1:0] rd_addr, op_addr;
  logic pb_clr, pb_we, op_start, busy, done, wel;
  logic [PAGE_W-1:0] pb_idx;
  logic [2:0] bp;
  op_kind_e op_kind;

  sfl_spi_if #(.CNT_W(CNT_W)) u_if (
    .clk_i, .rst_ni, .sclk_i, .cs_ni_i, .si_i, .hold_ni_i,
    .out_en_i(out_en), .tx_byte_i(tx_byte), .sel_o(sel),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .rx_valid_o(rx_valid),
    .rx_byte_o(rx_byte), .bit_cnt_o(bit_cnt), .tx_req_o(tx_req),
    .so_o, .so_oe_o
  );

  sfl_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLOCKS(BLOCKS), .CNT_W(CNT_W),
    .MFR_ID(MFR_ID), .DEV_HI(DEV_HI), .DEV_LO(DEV_LO), .SHORT_ID(SHORT_ID)
  ) u_ctrl (
    .clk_i, .rst_ni, .sel_i(sel), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .bit_cnt_i(bit_cnt),
    .tx_req_i(tx_req), .wp_ni_i, .busy_i(busy), .done_i(done),
    .rd_data_i(rd_data), .out_en_o(out_en), .tx_byte_o(tx_byte),
    .rd_addr_o(rd_addr), .pb_clr_o(pb_clr), .pb_we_o(pb_we),
    .pb_idx_o(pb_idx), .pb_data_o(pb_data), .op_start_o(op_start),
    .op_kind_o(op_kind), .op_addr_o(op_addr), .wel_o(wel), .bp_o(bp)
  );

  sfl_array #(
    .PAGE_BYTES(PAGE_BYTES), .SEC_BYTES(SEC_BYTES), .BLK_BYTES(BLK_BYTES),
    .MEM_BYTES(MEM_BYTES), .OP_WAIT(OP_WAIT), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
  ) u_array (
    .clk_i, .rst_ni, .start_i(op_start), .kind_i(op_kind), .addr_i(op_addr),
    .pb_clr_i(pb_clr), .pb_we_i(pb_we), .pb_idx_i(pb_idx), .pb_data_i(pb_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy), .done_o(done)
  );
endmodule

// File: rtl/spi_nor_dev_chk.sv
module spi_nor_dev_chk import sfl_pkg::*; (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     cs_ni_i,
  input logic     hold_ni_i,
  input logic     so_oe_o,
  input logic     busy,
  input logic     wel,
  input logic     op_start,
  input op_kind_e op_kind,
  input logic [2:0] bp
);
  AST_OE_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni_i) |-> !so_oe_o); // R1
  AST_HOLD_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hold_ni_i) |-> !so_oe_o); // R12
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> wel); // R5
  AST_WEL_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !op_start); // R8
  AST_CHIP_UNPROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_start && op_kind == K_CHIP) |-> (bp == 3'd0)); // R9
endmodule

bind spi_nor_dev spi_nor_dev_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni_i(cs_ni_i), .hold_ni_i(hold_ni_i),
  .so_oe_o(so_oe_o), .busy(busy), .wel(wel), .op_start(op_start),
  .op_kind(op_kind), .bp(bp)
);

// File: tb/spi_nor_dev_bench.sv
module spi_nor_dev_bench;
  localparam int MEM = 1024, PAGE = 16, SEC = 64, BLK = 256, WAITC = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int checks = 0, errors = 0;
  bit mode3 = 1'b0;

  logic [7:0] bmem [MEM];
  bit wel_m = 1'b0, lock_m = 1'b0;
  logic [2:0] bp_m = 3'd0;

  always #2 clk = ~clk;

  spi_nor_dev u_spi_nor_dev (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni_i(cs_n), .si_i(si),
    .hold_ni_i(hold_n), .wp_ni_i(wp_n), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit prot_m(input int a, input logic [2:0] lvl);
    int n;
    if (lvl == 0) n = 0; else if (lvl - 1 >= 2) n = 4; else n = 1 << (lvl - 1);
    return (a / BLK) >= 4 - n;
  endfunction

  function automatic logic [7:0] st_m(input bit busy);
    return {lock_m, 2'b00, bp_m, wel_m, busy};
  endfunction

  task automatic cs_low();
    sclk = mode3; tick(2); cs_n = 1'b0; tick(4);
  endtask
  task automatic cs_high();
    if (!mode3) sclk = 1'b0;
    tick(4); cs_n = 1'b1; tick(6);
  endtask
  task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] q);
    q = 8'h00;
    for (int i = 7; i >= 8 - n; i--) begin
      sclk = 1'b0; si = d[i]; tick(4); q[i] = so; sclk = 1'b1; tick(4);
    end
  endtask
  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    xbits(d, 8, q);
  endtask
  task automatic send_addr(input int a);
    logic [7:0] q;
    xfer(8'(a >> 16), q); xfer(8'(a >> 8), q); xfer(8'(a), q);
  endtask
  task automatic cmd1(input logic [7:0] c);
    logic [7:0] q;
    cs_low(); xfer(c, q); cs_high();
  endtask
  task automatic rdsr_chk(input string req, input logic [7:0] exp);
    logic [7:0] q;
    cs_low(); xfer(8'h05, q); xfer(8'h00, q); chk(req, q, exp);
    xfer(8'h00, q); chk(req, q, exp); cs_high();
  endtask
  task automatic read_chk(input string req, input int a, input int n);
    logic [7:0] q;
    cs_low(); xfer(8'h03, q); send_addr(a);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, q); chk(req, q, bmem[(a + k) % MEM]);
    end
    cs_high();
  endtask
  task automatic wren();
    cmd1(8'h06); if (!lock_m || 1) wel_m = 1'b1;
  endtask

  task automatic do_pp(input string req, input int a, input int n);
    logic [7:0] q;
    logic [7:0] pb [PAGE];
    bit run;
    int col;
    for (int i = 0; i < PAGE; i++) pb[i] = 8'hFF;
    col = a % PAGE;
    run = wel_m && !prot_m(a, bp_m);
    cs_low(); xfer(8'h02, q); send_addr(a);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      pb[col] = d; xfer(d, q); col = (col + 1) % PAGE;
    end
    cs_high();
    rdsr_chk(req, st_m(run));
    if (run) begin
      for (int i = 0; i < PAGE; i++) bmem[(a / PAGE) * PAGE + i] &= pb[i];
      tick(PAGE + WAITC + 20); wel_m = 1'b0;
      rdsr_chk("R5 wel cleared after program", st_m(1'b0));
    end
  endtask

  task automatic do_erase(input string req, input logic [7:0] op, input int a, input int span);
    logic [7:0] q;
    bit run;
    run = wel_m && ((op == 8'hC7) ? (bp_m == 0) : !prot_m(a, bp_m));
    cs_low(); xfer(op, q); if (op != 8'hC7) send_addr(a); cs_high();
    rdsr_chk(req, st_m(run));
    if (run) begin
      for (int i = 0; i < span; i++) bmem[(a / span) * span + i] = 8'hFF;
      tick(span + WAITC + 20); wel_m = 1'b0;
      rdsr_chk("R5 wel cleared after erase", st_m(1'b0));
    end
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] q;
    bit run;
    run = wel_m && !(lock_m && !wp_n);
    cs_low(); xfer(8'h01, q); xfer(v, q); cs_high();
    if (run) begin bp_m = v[4:2]; lock_m = v[7]; wel_m = 1'b0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    void'($urandom(32'd4242));
    for (int i = 0; i < MEM; i++) bmem[i] = 8'hFF;
    tick(5); rst_n = 1'b1; tick(3);

    chk("R1 so_oe low after reset", so_oe, 1'b0);
    rdsr_chk("R3 status after reset", 8'h00);

    cs_low(); xfer(8'h9F, q);
    xfer(0, q); chk("R4 id byte0", q, 8'hA7);
    xfer(0, q); chk("R4 id byte1", q, 8'h3C);
    xfer(0, q); chk("R4 id byte2", q, 8'h14);
    xfer(0, q); chk("R4 id wraps", q, 8'hA7);
    cs_high();
    cs_low(); xfer(8'hAB, q); send_addr(0); xfer(0, q); chk("R4 short id", q, 8'h13); cs_high();

    read_chk("R2 erased read", 0, 4);
    wren(); rdsr_chk("R5 wel set", st_m(1'b0));
    cmd1(8'h04); wel_m = 1'b0; rdsr_chk("R5 wel cleared by disable", st_m(1'b0));
    do_pp("R5 program without latch ignored", 32, 4);
    read_chk("R5 data untouched", 32, 4);

    for (int it = 0; it < 10; it++) begin
      int pg, c, n;
      pg = $urandom % 48; c = $urandom % PAGE; n = 1 + $urandom % 20;
      wren(); do_pp("R8 busy after program", pg * PAGE + c, n);
      read_chk("R6 page contents", pg * PAGE, PAGE);
    end
    wren(); do_pp("R6 second program ANDs", 5 * PAGE + 3, 18);
    read_chk("R6 AND result", 5 * PAGE, PAGE);

    mode3 = 1'b1;
    wren(); do_pp("R8 busy after program top", MEM - PAGE, PAGE);
    read_chk("R2 wrap at end mode3", MEM - 3, 6);
    cs_low(); xfer(8'h9F, q); xfer(0, q); chk("R1 mode3 id", q, 8'hA7); cs_high();
    mode3 = 1'b0;

    wren(); do_erase("R8 busy after sector erase", 8'h20, SEC * ($urandom % 12) + 5, SEC);
    read_chk("R7 sector erased", 0, 8);
    for (int s = 0; s < 12; s++) read_chk("R7 sector scan", s * SEC, 2);

    // busy window: other commands ignored
    wren();
    cs_low(); xfer(8'hD8, q); send_addr(BLK + 7); cs_high();
    cmd1(8'h04);
    rdsr_chk("R8 disable ignored while busy", 8'h03);
    cs_low(); xfer(8'h03, q); send_addr(0);
    for (int k = 0; k < 2; k++) begin
      sclk = 1'b0; tick(4); chk("R8 read ignored while busy", so_oe, 1'b0);
      sclk = 1'b1; tick(4);
    end
    cs_high();
    for (int i = 0; i < BLK; i++) bmem[BLK + i] = 8'hFF;
    tick(BLK + WAITC + 20); wel_m = 1'b0;
    rdsr_chk("R5 wel cleared after block erase", 8'h00);
    read_chk("R7 block erased", BLK, 4);
    read_chk("R7 block erased end", 2 * BLK - 4, 4);

    // length checks
    wren();
    cs_low(); xfer(8'h20, q); send_addr(0); xbits(8'h00, 1, q); cs_high();
    rdsr_chk("R11 erase with extra bit discarded", 8'h02);
    cs_low(); xfer(8'h02, q); send_addr(0); xfer(8'h00, q); xbits(8'h00, 3, q); cs_high();
    rdsr_chk("R11 program with partial byte discarded", 8'h02);
    read_chk("R11 data untouched", 0, 4);
    cmd1(8'h04); wel_m = 1'b0;
    cs_low(); xbits(8'h06, 7, q); cs_high();
    rdsr_chk("R11 short enable discarded", 8'h00);

    // protection
    wren(); wrsr(8'h04); rdsr_chk("R10 level 1 written", 8'h04);
    wren(); do_pp("R9 program in top block ignored", 3 * BLK + 2, 4);
    read_chk("R9 top block untouched", 3 * BLK, 8);
    do_pp("R9 program below top allowed", 2 * BLK + 16, 4);
    read_chk("R9 allowed program", 2 * BLK + 16, 4);
    wren(); do_erase("R9 chip erase ignored", 8'hC7, 0, MEM);
    cmd1(8'h04); wel_m = 1'b0;
    wren(); wrsr(8'h08);
    wren(); do_erase("R9 level 2 protects block 2", 8'h20, 2 * BLK, SEC);
    read_chk("R9 block 2 intact", 2 * BLK + 16, 4);
    cmd1(8'h04); wel_m = 1'b0;
    wren(); wrsr(8'h0C);
    wren(); do_erase("R9 level 3 protects all", 8'h20, 0, SEC);
    cmd1(8'h04); wel_m = 1'b0;

    // lock with guard pin
    wren(); wrsr(8'h80); rdsr_chk("R10 lock set", 8'h80);
    wp_n = 1'b0;
    wren(); wrsr(8'h04); rdsr_chk("R10 status write blocked by guard", 8'h82);
    wp_n = 1'b1;
    wrsr(8'h00); rdsr_chk("R10 status write with guard released", 8'h00);

    // hold during read
    cs_low(); xfer(8'h03, q); send_addr(16);
    xfer(0, q); chk("R12 byte before hold", q, bmem[16]);
    hold_n = 1'b0; tick(3);
    for (int k = 0; k < 8; k++) begin
      sclk = 1'b0; si = 1'b1; tick(4); chk("R12 output off in hold", so_oe, 1'b0);
      sclk = 1'b1; tick(4);
    end
    hold_n = 1'b1; tick(3);
    xfer(0, q); chk("R12 byte after hold", q, bmem[17]);
    xfer(0, q); chk("R12 next byte after hold", q, bmem[18]);
    cs_high();
    chk("R1 output off when deselected", so_oe, 1'b0);

    wren(); do_erase("R8 busy after chip erase", 8'hC7, 0, MEM);
    read_chk("R7 chip erased", 16, 4);
    read_chk("R7 chip erased top", MEM - 4, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule